// File: doc/BRIEF.md
# Masked Poll Waiter

The block runs one wait-on-value command at a time. A command names a source (register space, memory, or memory through the L2 cache path), a reference value, a mask and a compare function. The block reads a 32-bit value from the register read port or from the memory read port and ANDs it with the mask. It then compares the result, unsigned, against the reference. When the compare holds, the block pulses `done` so the command stream can move on. When it fails, the block waits the programmed poll interval and reads again.

An optional limit makes the block give up. At a failing result, if the number of cycles since the command was accepted has reached the limit, the block ends with a `timed_out` pulse instead of `done`.

A second operation mode, write-wait-write, works in register space only. The block first writes the reference to the low register offset. It then polls the high register offset until the value there equals the reference. Finally it writes the reference to the high register offset.

Top module: `poll_waiter`

## Requirements
- R1: After reset, `busy`, `done`, `timed_out`, `func_err`, `reg_rd_req`, `mem_rd_req` and `reg_wr_en` are all low.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. The command word carries the compare function in bits 2:0, the source space in bits 5:4 and the operation in bits 7:6. Every other bit has no effect. A `cmd_valid` that arrives while `busy` is high is ignored.
- R3: The value read is ANDed with the mask and compared unsigned with the reference. Function codes are: 0 always, 1 less, 2 less-or-equal, 3 equal, 4 not-equal, 5 greater-or-equal, 6 greater. A true compare ends the command with a one-cycle `done`.
- R4: Function code 7 behaves as always-true. It raises `func_err` from the cycle after acceptance until the next command is accepted. Any other function code leaves `func_err` low.
- R5: Space 0 reads on the register port at offset `cmd_addr_lo[REG_AW-1:0]`, and `cmd_addr_hi` is ignored. Spaces 1, 2 and 3 read on the memory port at address {`cmd_addr_hi`,`cmd_addr_lo`}. `mem_rd_l2` is high only for space 2.
- R6: After a failing result, the next read request comes exactly `cmd_interval` cycles after the edge that accepts that result. An interval of 0 means the very next cycle. Every request lasts one cycle.
- R7: The elapsed count equals the number of cycles from the accepting edge to the edge that takes a result. If `cmd_limit` is non-zero and a failing result sees an elapsed count of at least `cmd_limit`, the command ends with a one-cycle `timed_out`, without `done` and without any further read. A `cmd_limit` of 0 never times out.
- R8: Operation 1 with space 0 runs these steps in order: write the reference to offset `cmd_addr_lo[REG_AW-1:0]`; poll offset `cmd_addr_hi[REG_AW-1:0]` with equality, whatever the function field says; write the reference to the high offset; then `done`. Operation 1 in any other space, and operations 2 and 3, act as a plain wait with no writes.
- R9: `done` and `timed_out` are single-cycle pulses, never high together, and `busy` is low while either is high.
- R10: A true compare ends with `done` even when the elapsed count has already reached the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ctrl | input | 32 | Command word: function, space, operation |
| cmd_addr_lo | input | DATA_W | Low poll address or register offset |
| cmd_addr_hi | input | DATA_W | High poll address or second register offset |
| cmd_ref | input | DATA_W | Reference value |
| cmd_mask | input | DATA_W | Mask applied to the value read |
| cmd_interval | input | INTV_W | Cycles to wait between failed poll and next read |
| cmd_limit | input | TMO_W | Timeout limit in cycles, 0 disables |
| busy | output | 1 | A command is in progress |
| reg_rd_req | output | 1 | Register read request, one cycle |
| reg_rd_addr | output | REG_AW | Register read offset |
| reg_rd_valid | input | 1 | Register read data valid |
| reg_rd_data | input | DATA_W | Register read data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | REG_AW | Register write offset |
| reg_wr_data | output | DATA_W | Register write data |
| mem_rd_req | output | 1 | Memory read request, one cycle |
| mem_rd_addr | output | 2*DATA_W | Memory read address |
| mem_rd_l2 | output | 1 | Memory read goes through the L2 path |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | DATA_W | Memory read data |
| done | output | 1 | Condition met, one-cycle pulse |
| timed_out | output | 1 | Wait aborted by limit, one-cycle pulse |
| func_err | output | 1 | Last accepted command used function code 7 |

## Verification
The bench builds the block with its default parameters: 32-bit data, 16-bit register offsets, a 16-bit interval and a 20-bit limit. The 32-bit width lets the table place values on either side of the sign boundary, so an unsigned compare and a signed compare give different answers. A 16-bit offset is narrower than the high address word, which shows that only the low bits of each address reach the register port. A 20-bit limit leaves room for short limits that end a wait after a known number of polls.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam int CTL_W         = 32;
  localparam int CTL_FUNC_LSB  = 0;
  localparam int CTL_SPACE_LSB = 4;
  localparam int CTL_OP_LSB    = 6;

  typedef enum logic [2:0] {
    FN_ALWAYS = 3'd0,
    FN_LT     = 3'd1,
    FN_LE     = 3'd2,
    FN_EQ     = 3'd3,
    FN_NE     = 3'd4,
    FN_GE     = 3'd5,
    FN_GT     = 3'd6,
    FN_RSVD   = 3'd7
  } pw_func_e;

  typedef enum logic [1:0] {
    SP_REG  = 2'd0,
    SP_MEM  = 2'd1,
    SP_L2   = 2'd2,
    SP_RSVD = 2'd3
  } pw_space_e;

  typedef enum logic [1:0] {
    OP_WAIT = 2'd0,
    OP_WWW  = 2'd1,
    OP_R2   = 2'd2,
    OP_R3   = 2'd3
  } pw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_WR,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD,
    ST_POST_WR
  } pw_state_e;

endpackage

// File: rtl/pw_match_unit.sv
module pw_match_unit
  import pw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        func,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] refv,
  output logic              hit,
  output logic              bad_func
);

  // Unsigned relation between a masked value and the reference.
  function automatic logic relate(input logic [2:0] f,
                                  input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b);
    case (pw_func_e'(f))
      FN_LT:   return a <  b;
      FN_LE:   return a <= b;
      FN_EQ:   return a == b;
      FN_NE:   return a != b;
      FN_GE:   return a >= b;
      FN_GT:   return a >  b;
      default: return 1'b1;
    endcase
  endfunction

  assign hit      = relate(func, value & mask, refv);
  assign bad_func = (func == FN_RSVD);

endmodule

// File: rtl/pw_gap_timer.sv
module pw_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == W'(1));

endmodule

// File: rtl/pw_age_counter.sv
module pw_age_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] limit,
  output logic         over
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (start)      age <= W'(1);
    else if (age != TOP) age <= age + 1'b1;
  end

  assign over = (limit != '0) && (age >= limit);

endmodule

// File: rtl/poll_waiter.sv
module poll_waiter
  import pw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 16,
  parameter int INTV_W = 16,
  parameter int TMO_W  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [31:0]         cmd_ctrl,
  input  logic [DATA_W-1:0]   cmd_addr_lo,
  input  logic [DATA_W-1:0]   cmd_addr_hi,
  input  logic [DATA_W-1:0]   cmd_ref,
  input  logic [DATA_W-1:0]   cmd_mask,
  input  logic [INTV_W-1:0]   cmd_interval,
  input  logic [TMO_W-1:0]    cmd_limit,
  output logic                busy,
  output logic                reg_rd_req,
  output logic [REG_AW-1:0]   reg_rd_addr,
  input  logic                reg_rd_valid,
  input  logic [DATA_W-1:0]   reg_rd_data,
  output logic                reg_wr_en,
  output logic [REG_AW-1:0]   reg_wr_addr,
  output logic [DATA_W-1:0]   reg_wr_data,
  output logic                mem_rd_req,
  output logic [2*DATA_W-1:0] mem_rd_addr,
  output logic                mem_rd_l2,
  input  logic                mem_rd_valid,
  input  logic [DATA_W-1:0]   mem_rd_data,
  output logic                done,
  output logic                timed_out,
  output logic                func_err
);

  localparam int MEM_AW = 2 * DATA_W;

  // Command word decode
  logic [2:0] c_func;
  logic [1:0] c_space;
  logic [1:0] c_op;
  logic       c_ww;
  assign c_func  = cmd_ctrl[CTL_FUNC_LSB  +: 3];
  assign c_space = cmd_ctrl[CTL_SPACE_LSB +: 2];
  assign c_op    = cmd_ctrl[CTL_OP_LSB    +: 2];
  assign c_ww    = (c_op == OP_WWW) && (c_space == SP_REG);

  // Latched command
  pw_state_e           st;
  logic [2:0]          f_q;
  logic [1:0]          space_q;
  logic                ww_q;
  logic [DATA_W-1:0]   lo_q, hi_q, ref_q, mask_q;
  logic [INTV_W-1:0]   intv_q;
  logic [TMO_W-1:0]    lim_q;
  logic                err_q, done_q, to_q;

  // Named internal events
  logic              ev_accept;
  logic              ev_result;
  logic              ev_hit;
  logic              ev_over;
  logic              ev_gap_done;
  logic              ev_gap_load;
  logic              is_reg;
  logic [DATA_W-1:0] rd_value;
  logic              unused_bad;

  assign is_reg    = (space_q == SP_REG);
  assign ev_accept = cmd_valid && (st == ST_IDLE);
  assign rd_value  = is_reg ? reg_rd_data : mem_rd_data;
  assign ev_result = (st == ST_WAIT) && (is_reg ? reg_rd_valid : mem_rd_valid);
  assign ev_gap_load = ev_result && !ev_hit && !ev_over && (intv_q != '0);

  pw_match_unit #(.DATA_W(DATA_W)) u_match (
    .func     (f_q),
    .value    (rd_value),
    .mask     (mask_q),
    .refv     (ref_q),
    .hit      (ev_hit),
    .bad_func (unused_bad)
  );

  pw_gap_timer #(.W(INTV_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_gap_load),
    .load_val (intv_q),
    .expire   (ev_gap_done)
  );

  pw_age_counter #(.W(TMO_W)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ev_accept),
    .limit (lim_q),
    .over  (ev_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      f_q     <= '0;
      space_q <= '0;
      ww_q    <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      ref_q   <= '0;
      mask_q  <= '0;
      intv_q  <= '0;
      lim_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (ev_accept) begin
            f_q     <= c_ww ? 3'(FN_EQ) : c_func;
            space_q <= c_space;
            ww_q    <= c_ww;
            lo_q    <= cmd_addr_lo;
            hi_q    <= cmd_addr_hi;
            ref_q   <= cmd_ref;
            mask_q  <= cmd_mask;
            intv_q  <= cmd_interval;
            lim_q   <= cmd_limit;
            err_q   <= (c_func == FN_RSVD);
            st      <= c_ww ? ST_PRE_WR : ST_ISSUE;
          end
        end
        ST_PRE_WR: st <= ST_ISSUE;
        ST_ISSUE:  st <= ST_WAIT;
        ST_WAIT: begin
          if (ev_result) begin
            if (ev_hit) begin
              if (ww_q) st <= ST_POST_WR;
              else begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
              end
            end else if (ev_over) begin
              st   <= ST_IDLE;
              to_q <= 1'b1;
            end else if (intv_q == '0) begin
              st <= ST_ISSUE;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (ev_gap_done) st <= ST_ISSUE;
        ST_POST_WR: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st != ST_IDLE);
  assign reg_rd_req  = (st == ST_ISSUE) && is_reg;
  assign reg_rd_addr = ww_q ? hi_q[REG_AW-1:0] : lo_q[REG_AW-1:0];
  assign reg_wr_en   = (st == ST_PRE_WR) || (st == ST_POST_WR);
  assign reg_wr_addr = (st == ST_PRE_WR) ? lo_q[REG_AW-1:0] : hi_q[REG_AW-1:0];
  assign reg_wr_data = ref_q;
  assign mem_rd_req  = (st == ST_ISSUE) && !is_reg;
  assign mem_rd_addr = MEM_AW'({hi_q, lo_q});
  assign mem_rd_l2   = mem_rd_req && (space_q == SP_L2);
  assign done        = done_q;
  assign timed_out   = to_q;
  assign func_err    = err_q;

endmodule

// File: rtl/pw_checker.sv
module pw_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timed_out,
  input logic reg_rd_req,
  input logic mem_rd_req,
  input logic reg_wr_en,
  input logic mem_rd_l2
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> !timed_out);

  // R9
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timed_out));

  // R9
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timed_out) |-> !busy);

  // R5
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_req && mem_rd_req));

  // R5
  l2_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_l2 |-> mem_rd_req);

  // R2
  act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_req || mem_rd_req || reg_wr_en) |-> busy);

  // R6
  reg_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> !reg_rd_req);

  // R6
  mem_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

endmodule

bind poll_waiter pw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .timed_out  (timed_out),
  .reg_rd_req (reg_rd_req),
  .mem_rd_req (mem_rd_req),
  .reg_wr_en  (reg_wr_en),
  .mem_rd_l2  (mem_rd_l2)
);

// File: tb/sim_poll_waiter.sv
`timescale 1ns/1ps
module sim_poll_waiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_ctrl = '0;
  logic [31:0] cmd_addr_lo = '0, cmd_addr_hi = '0, cmd_ref = '0, cmd_mask = '0;
  logic [15:0] cmd_interval = '0;
  logic [19:0] cmd_limit = '0;
  logic        busy, reg_rd_req, reg_wr_en, mem_rd_req, mem_rd_l2;
  logic        done, timed_out, func_err;
  logic [15:0] reg_rd_addr, reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic [63:0] mem_rd_addr;
  logic        reg_rd_valid = 1'b0, mem_rd_valid = 1'b0;
  logic [31:0] reg_rd_data = '0, mem_rd_data = '0;

  always #2 clk = ~clk;

  poll_waiter u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
    .cmd_addr_lo(cmd_addr_lo), .cmd_addr_hi(cmd_addr_hi), .cmd_ref(cmd_ref),
    .cmd_mask(cmd_mask), .cmd_interval(cmd_interval), .cmd_limit(cmd_limit),
    .busy(busy), .reg_rd_req(reg_rd_req), .reg_rd_addr(reg_rd_addr),
    .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_l2(mem_rd_l2),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .timed_out(timed_out), .func_err(func_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Responder controls (written by main flow at posedge while idle)
  logic        clr_log = 1'b0;
  int          bad_n = 0;
  logic [31:0] bad_val = '0, good_val = '0;

  // Responder log
  int          n_reads = 0, n_reg = 0, n_mem = 0, n_wr = 0;
  int          req_cyc [32];
  int          wr_cyc [4];
  logic [15:0] wr_addr [4];
  logic [31:0] wr_data [4];
  logic [15:0] last_reg_addr = '0;
  logic [63:0] last_mem_addr = '0;
  logic        last_l2 = 1'b0;
  logic        p_reg = 1'b0, p_mem = 1'b0;
  logic [31:0] p_data = '0;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Read responder: data is returned two negedges after the request is seen,
  // so a read request at cycle c gives a result taken at edge c+2.
  initial forever begin
    @(negedge clk);
    reg_rd_valid <= p_reg;
    mem_rd_valid <= p_mem;
    reg_rd_data  <= p_data;
    mem_rd_data  <= p_data;
    p_reg <= reg_rd_req;
    p_mem <= mem_rd_req;
    if (clr_log) begin
      n_reads <= 0; n_reg <= 0; n_mem <= 0; n_wr <= 0;
    end else begin
      if (reg_rd_req || mem_rd_req) begin
        p_data <= (n_reads < bad_n) ? bad_val : good_val;
        if (n_reads < 32) req_cyc[n_reads] <= cyc;
        n_reads <= n_reads + 1;
      end
      if (reg_rd_req) begin
        n_reg <= n_reg + 1;
        last_reg_addr <= reg_rd_addr;
      end
      if (mem_rd_req) begin
        n_mem <= n_mem + 1;
        last_mem_addr <= mem_rd_addr;
        last_l2 <= mem_rd_l2;
      end
      if (reg_wr_en) begin
        if (n_wr < 4) begin
          wr_addr[n_wr] <= reg_wr_addr;
          wr_data[n_wr] <= reg_wr_data;
          wr_cyc[n_wr]  <= cyc;
        end
        n_wr <= n_wr + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Reads issued before a timeout, from R6/R7: results land at elapsed
  // 2, 2+(intv+2), ... with this responder's two-cycle latency.
  function automatic int reads_to_timeout(input int intv, input int lim);
    int e = 2;
    int k = 1;
    while (e < lim) begin
      e += intv + 2;
      k++;
    end
    return k;
  endfunction

  task automatic set_resp(input int nb, input logic [31:0] bv, input logic [31:0] gv);
    @(posedge clk);
    bad_n = nb; bad_val = bv; good_val = gv; clr_log = 1'b1;
    @(posedge clk);
    clr_log = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] ctrl, input logic [31:0] lo,
                         input logic [31:0] hi, input logic [31:0] refv,
                         input logic [31:0] maskv, input int intv, input int lim,
                         input int poke_at, output bit got_done, output bit got_to);
    got_done = 1'b0;
    got_to   = 1'b0;
    @(negedge clk);
    cmd_ctrl = ctrl; cmd_addr_lo = lo; cmd_addr_hi = hi; cmd_ref = refv;
    cmd_mask = maskv; cmd_interval = 16'(intv); cmd_limit = 20'(lim);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (i == poke_at) begin
        cmd_ctrl = 32'h0;
        cmd_valid = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
      if (done || timed_out) begin
        got_done = done;
        got_to = timed_out;
        break;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    if (!got_done && !got_to) chk(1'b0, "R9", "command never ended", 0, 1);
    @(negedge clk);
    @(negedge clk);
  endtask

  // {space[2], func[3], mask[32], ref[32], data[32], hit[1]}
  localparam int NV = 12;
  localparam logic [101:0] VEC [NV] = '{
    {2'd0, 3'd0, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0000, 1'b1},
    {2'd1, 3'd1, 32'h0000_00FF, 32'h0000_0005, 32'h0000_0003, 1'b1},
    {2'd2, 3'd1, 32'h0000_00FF, 32'h0000_0005, 32'h0000_0005, 1'b0},
    {2'd0, 3'd2, 32'h0000_00FF, 32'h0000_0005, 32'h0000_0005, 1'b1},
    {2'd1, 3'd3, 32'h0000_00FF, 32'h0000_00AB, 32'h1234_56AB, 1'b1},
    {2'd2, 3'd3, 32'h0000_00FF, 32'h0000_0013, 32'h0000_0012, 1'b0},
    {2'd3, 3'd4, 32'h0000_00FF, 32'h0000_0013, 32'h0000_0012, 1'b1},
    {2'd0, 3'd5, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1},
    {2'd1, 3'd6, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0},
    {2'd2, 3'd6, 32'hFFFF_FFFF, 32'h0000_0009, 32'h0000_0009, 1'b0},
    {2'd0, 3'd5, 32'hFFFF_FFFF, 32'h0000_0009, 32'h0000_0004, 1'b0},
    {2'd1, 3'd4, 32'h0000_00FF, 32'h0000_0034, 32'h0000_1234, 1'b0}
  };

  initial begin
    #(150000 * 4);
    chk(1'b0, "R9", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    bit gd, gt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !timed_out && !func_err, "R1", "status in reset",
        {busy, done, timed_out, func_err}, 0);
    chk(!reg_rd_req && !mem_rd_req && !reg_wr_en, "R1", "requests in reset",
        {reg_rd_req, mem_rd_req, reg_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !timed_out && !func_err, "R1", "status after reset",
        {busy, done, timed_out, func_err}, 0);

    // R3 R5 R10 R2: table walk, one read each, limit 1 makes a miss time out
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  sp;
      logic [2:0]  fn;
      logic        exp_hit;
      logic [31:0] ctrl;
      sp = VEC[v][101:100];
      fn = VEC[v][99:97];
      exp_hit = VEC[v][0];
      ctrl = 32'h0000_0100 | 32'(fn) | (32'(sp) << 4);  // engine bits set, no effect
      set_resp(0, 32'h0, VEC[v][32:1]);
      run_cmd(ctrl, 32'h0000_1040, 32'hABCD_0007, VEC[v][64:33], VEC[v][96:65],
              0, 1, -1, gd, gt);
      chk(gd == exp_hit, "R3", $sformatf("vector %0d done", v), gd, exp_hit);
      chk(gt == !exp_hit, "R10", $sformatf("vector %0d timed_out", v), gt, !exp_hit);
      chk(n_reads == 1, "R7", $sformatf("vector %0d read count", v), n_reads, 1);
      if (sp == 2'd0) begin
        chk(n_reg == 1 && last_reg_addr == 16'h1040, "R5",
            $sformatf("vector %0d register offset", v), last_reg_addr, 16'h1040);
      end else begin
        chk(n_mem == 1 && last_mem_addr == 64'hABCD_0007_0000_1040, "R5",
            $sformatf("vector %0d memory address", v), last_mem_addr,
            64'hABCD_0007_0000_1040);
        chk(last_l2 == (sp == 2'd2), "R5", $sformatf("vector %0d l2 flag", v),
            last_l2, (sp == 2'd2));
      end
    end

    // R4: reserved function code is always-true and raises the error flag
    set_resp(3, 32'h0, 32'h0);
    run_cmd(32'h0000_0017, 32'h40, 32'h0, 32'h1, 32'hFFFF_FFFF, 0, 0, -1, gd, gt);
    chk(gd && n_reads == 1, "R4", "function 7 done on first read", n_reads, 1);
    chk(func_err == 1'b1, "R4", "func_err after function 7", func_err, 1);
    set_resp(0, 32'h0, 32'h0);
    run_cmd(32'h0000_0010, 32'h40, 32'h0, 32'h1, 32'hFFFF_FFFF, 0, 0, -1, gd, gt);
    chk(func_err == 1'b0, "R4", "func_err cleared by next command", func_err, 0);

    // R6: retry spacing with interval 4
    set_resp(2, 32'h11, 32'h5A);
    run_cmd(32'h0000_0013, 32'h80, 32'h1, 32'h5A, 32'hFF, 4, 0, -1, gd, gt);
    chk(gd && n_reads == 3, "R6", "reads with interval 4", n_reads, 3);
    chk(req_cyc[1] - req_cyc[0] == 6, "R6", "gap 1 interval 4", req_cyc[1] - req_cyc[0], 6);
    chk(req_cyc[2] - req_cyc[1] == 6, "R6", "gap 2 interval 4", req_cyc[2] - req_cyc[1], 6);

    // R6: interval 0 retries back to back after the result
    set_resp(1, 32'h11, 32'h5A);
    run_cmd(32'h0000_0003, 32'h80, 32'h1, 32'h5A, 32'hFF, 0, 0, -1, gd, gt);
    chk(gd && n_reads == 2, "R6", "reads with interval 0", n_reads, 2);
    chk(req_cyc[1] - req_cyc[0] == 2, "R6", "gap interval 0", req_cyc[1] - req_cyc[0], 2);

    // R7: timeout after limit
    set_resp(1000, 32'h11, 32'h5A);
    run_cmd(32'h0000_0013, 32'h80, 32'h1, 32'h5A, 32'hFF, 3, 20, -1, gd, gt);
    chk(gt && !gd, "R7", "timed out without done", {gd, gt}, 2'b01);
    chk(n_reads == reads_to_timeout(3, 20), "R7", "reads before timeout",
        n_reads, reads_to_timeout(3, 20));
    repeat (20) @(negedge clk);
    chk(n_reads == reads_to_timeout(3, 20) && !busy, "R7", "no read after timeout",
        n_reads, reads_to_timeout(3, 20));

    // R7: limit 0 never times out
    set_resp(12, 32'h11, 32'h5A);
    run_cmd(32'h0000_0013, 32'h80, 32'h1, 32'h5A, 32'hFF, 0, 0, -1, gd, gt);
    chk(gd && !gt && n_reads == 13, "R7", "limit 0 keeps polling", n_reads, 13);

    // R8: write-wait-write in register space, function field says greater
    set_resp(2, 32'h99, 32'h55);
    run_cmd(32'h0000_0046, 32'h0000_0010, 32'hABCD_0020, 32'h55, 32'hFFFF_FFFF,
            0, 0, -1, gd, gt);
    chk(gd && n_reads == 3, "R8", "polls until equal", n_reads, 3);
    chk(last_reg_addr == 16'h0020, "R8", "poll at high offset", last_reg_addr, 16'h20);
    chk(n_wr == 2, "R8", "write count", n_wr, 2);
    chk(wr_addr[0] == 16'h0010 && wr_data[0] == 32'h55, "R8", "first write",
        {wr_addr[0], wr_data[0]}, {16'h0010, 32'h55});
    chk(wr_addr[1] == 16'h0020 && wr_data[1] == 32'h55, "R8", "last write",
        {wr_addr[1], wr_data[1]}, {16'h0020, 32'h55});
    chk(wr_cyc[0] < req_cyc[0] && wr_cyc[1] > req_cyc[2], "R8", "write order",
        wr_cyc[1], req_cyc[2] + 1);

    // R8: operation 1 in memory space is a plain wait
    set_resp(0, 32'h0, 32'h77);
    run_cmd(32'h0000_0053, 32'h10, 32'h20, 32'h77, 32'hFF, 0, 0, -1, gd, gt);
    chk(gd && n_wr == 0 && n_mem == 1, "R8", "no writes outside register space", n_wr, 0);

    // R2: a command offered while busy is ignored
    set_resp(1000, 32'h11, 32'h5A);
    run_cmd(32'h0000_0013, 32'h80, 32'h1, 32'h5A, 32'hFF, 2, 15, 3, gd, gt);
    chk(gt && !gd, "R2", "busy command ignored", {gd, gt}, 2'b01);
    chk(n_reads == reads_to_timeout(2, 15), "R2", "reads unchanged by busy command",
        n_reads, reads_to_timeout(2, 15));

    finish_run();
  end

endmodule